// File: doc/BRIEF.md
# Add/Subtract Cell with Carry Vector

This block is a combinational adder cell of configurable width. It adds two operands and a carry-in. A single invert control flips every bit of the second operand before the addition. Along with the sum it returns two more vectors of the same width: the per-bit propagate term and the carry leaving every bit position. Setting the invert control and the carry-in together turns the cell into a subtractor. The top carry bit then reads as "no borrow".

Each operand is first fitted to the result width. It is sign-extended or zero-extended, as chosen by a parameter for that operand alone, or cut down if it is wider than the result. A shadow path runs beside the data. Every input bit has an "unknown" flag carried as an ordinary bit. The cell derives flag vectors for the sum, the propagate vector and the carry vector from these. Any data output bit whose flag is set is forced to 0, so the outputs never depend on unknown inputs. There are no registers, clocks or handshakes: results follow the inputs within the same cycle.

Top module: `addsub_carry_cell`

## Requirements
- R1: Each bit of `prop_o` equals the fitted A bit XOR the fitted B bit XOR `binv_i` (before masking by R8).
- R2: `sum_o` equals fitted A plus (fitted B XOR `binv_i` in every bit) plus `cin_i`, modulo 2^W (before masking).
- R3: Bit i of `carry_o` is the carry out of position i: the majority of the fitted A bit, the effective B bit, and the carry entering position i (`cin_i` at bit 0, `carry_o[i-1]` above it).
- R4: With `binv_i`=1 and `cin_i`=1, `sum_o` is A minus B modulo 2^W. `carry_o[W-1]` is 1 exactly when fitted A is not less than fitted B as unsigned values.
- R5: With the signed parameter set, an operand narrower than W is sign-extended; otherwise it is zero-extended. An operand wider than W keeps only its low W bits. The flag vectors are fitted the same way: a sign-extended operand copies its top flag, zero-extension adds clear flags, and the flags of dropped bits have no effect.
- R6: If any surviving flag of A or B, or the flag of `cin_i` or of `binv_i`, is set, every bit of `sum_unk_o` and of `carry_unk_o` is 1. Otherwise both are all 0.
- R7: Bit i of `prop_unk_o` is the OR of the fitted A flag i, the fitted B flag i and `binv_unk_i`.
- R8: Every data output bit whose matching flag bit is set reads 0.
- R9: `cin_unk_i` alone has no effect on `prop_o` or `prop_unk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | A_W | Operand A |
| opb_i | input | B_W | Operand B |
| cin_i | input | 1 | Carry into bit 0 |
| binv_i | input | 1 | Invert every bit of B |
| opa_unk_i | input | A_W | Unknown flags for A |
| opb_unk_i | input | B_W | Unknown flags for B |
| cin_unk_i | input | 1 | Unknown flag for the carry-in |
| binv_unk_i | input | 1 | Unknown flag for the invert control |
| sum_o | output | W | Sum, masked by its flags |
| prop_o | output | W | Propagate vector, masked by its flags |
| carry_o | output | W | Per-bit carry-out vector, masked by its flags |
| sum_unk_o | output | W | Unknown flags for the sum |
| prop_unk_o | output | W | Unknown flags for the propagate vector |
| carry_unk_o | output | W | Unknown flags for the carry vector |

## Verification
Arithmetic and the unknown-flag masking take effect in the same evaluation. The bench provokes this with subtractions in which one operand bit, or the invert control, is flagged. It then checks two things. First, the propagate bits that are not flagged still carry the correct subtraction value. Second, the sum and the carries read 0 under all-ones flags. A second overlap is fitting the operands together with the borrow. A sign-extended negative A and a truncated wide B are subtracted, and the top carry bit is compared with an unsigned comparison of the fitted values.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic {EXT_ZERO = 1'b0, EXT_SIGN = 1'b1} ext_mode_e;

  function automatic logic maj3(input logic p, input logic q, input logic r);
    return (p & q) | (p & r) | (q & r);
  endfunction
endpackage

// File: rtl/addsub_operand_ext.sv
module addsub_operand_ext #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 8,
  parameter addsub_pkg::ext_mode_e MODE = addsub_pkg::EXT_ZERO
) (
  input  logic [IN_W-1:0]  val_i,
  input  logic [IN_W-1:0]  unk_i,
  output logic [OUT_W-1:0] val_o,
  output logic [OUT_W-1:0] unk_o
);
  localparam int PAD_W = (OUT_W > IN_W) ? OUT_W - IN_W : 1;
  localparam int CUT_W = (IN_W > OUT_W) ? IN_W - OUT_W : 1;

  generate
    if (OUT_W > IN_W) begin : g_grow
      logic pad_val, pad_unk;
      if (MODE == addsub_pkg::EXT_SIGN) begin : g_sign
        assign pad_val = val_i[IN_W-1];
        assign pad_unk = unk_i[IN_W-1];
      end else begin : g_zero
        assign pad_val = 1'b0;
        assign pad_unk = 1'b0;
      end
      assign val_o = {{PAD_W{pad_val}}, val_i};
      assign unk_o = {{PAD_W{pad_unk}}, unk_i};
    end else if (OUT_W < IN_W) begin : g_cut
      logic [CUT_W-1:0] unused_hi;
      assign unused_hi = val_i[IN_W-1:OUT_W] ^ unk_i[IN_W-1:OUT_W];
      assign val_o = val_i[OUT_W-1:0];
      assign unk_o = unk_i[OUT_W-1:0];
    end else begin : g_same
      assign val_o = val_i;
      assign unk_o = unk_i;
    end
  endgenerate
endmodule

// File: rtl/addsub_bit_chain.sv
module addsub_bit_chain #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         binv_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] prop_o,
  output logic [W-1:0] carry_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   c_in;

  assign c_in[0] = cin_i;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign b_eff[i]   = b_i[i] ^ binv_i;
      assign prop_o[i]  = a_i[i] ^ b_eff[i];
      assign sum_o[i]   = prop_o[i] ^ c_in[i];
      assign carry_o[i] = addsub_pkg::maj3(a_i[i], b_eff[i], c_in[i]);
      assign c_in[i+1]  = carry_o[i];
    end
  endgenerate

  always_comb begin
    for (int k = 0; k < W; k++) begin
      AST_CARRY_RIPPLE: assert (carry_o[k] == ((a_i[k] & ~prop_o[k]) | (prop_o[k] & c_in[k])))
        else $error("carry generate/propagate mismatch"); // R3
    end
  end
endmodule

// File: rtl/addsub_unk_track.sv
module addsub_unk_track #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_unk_i,
  input  logic [W-1:0] b_unk_i,
  input  logic         cin_unk_i,
  input  logic         binv_unk_i,
  output logic [W-1:0] sum_unk_o,
  output logic [W-1:0] prop_unk_o,
  output logic [W-1:0] carry_unk_o
);
  logic any_unk;

  assign any_unk     = (|a_unk_i) | (|b_unk_i) | cin_unk_i | binv_unk_i;
  assign sum_unk_o   = {W{any_unk}};
  assign carry_unk_o = {W{any_unk}};

  generate
    for (genvar i = 0; i < W; i++) begin : g_prop
      assign prop_unk_o[i] = a_unk_i[i] | b_unk_i[i] | binv_unk_i;
    end
  endgenerate

  always_comb begin
    AST_PROP_IMPLIES_ANY: assert (((|prop_unk_o) == 1'b0) || (&sum_unk_o))
      else $error("propagate flag set without sum flags"); // R7
  end
endmodule

// File: rtl/addsub_carry_cell.sv
module addsub_carry_cell #(
  parameter int A_W      = 8,
  parameter int B_W      = 8,
  parameter int W        = 8,
  parameter bit A_SIGNED = 1'b0,
  parameter bit B_SIGNED = 1'b0
) (
  input  logic [A_W-1:0] opa_i,
  input  logic [B_W-1:0] opb_i,
  input  logic           cin_i,
  input  logic           binv_i,
  input  logic [A_W-1:0] opa_unk_i,
  input  logic [B_W-1:0] opb_unk_i,
  input  logic           cin_unk_i,
  input  logic           binv_unk_i,
  output logic [W-1:0]   sum_o,
  output logic [W-1:0]   prop_o,
  output logic [W-1:0]   carry_o,
  output logic [W-1:0]   sum_unk_o,
  output logic [W-1:0]   prop_unk_o,
  output logic [W-1:0]   carry_unk_o
);
  import addsub_pkg::*;

  localparam ext_mode_e A_MODE = A_SIGNED ? EXT_SIGN : EXT_ZERO;
  localparam ext_mode_e B_MODE = B_SIGNED ? EXT_SIGN : EXT_ZERO;

  logic [W-1:0] a_fit, b_fit, a_unk_fit, b_unk_fit;
  logic [W-1:0] sum_raw, prop_raw, carry_raw;

  addsub_operand_ext #(.IN_W(A_W), .OUT_W(W), .MODE(A_MODE)) u_ext_a (
    .val_i(opa_i), .unk_i(opa_unk_i), .val_o(a_fit), .unk_o(a_unk_fit)
  );

  addsub_operand_ext #(.IN_W(B_W), .OUT_W(W), .MODE(B_MODE)) u_ext_b (
    .val_i(opb_i), .unk_i(opb_unk_i), .val_o(b_fit), .unk_o(b_unk_fit)
  );

  addsub_bit_chain #(.W(W)) u_chain (
    .a_i(a_fit), .b_i(b_fit), .cin_i(cin_i), .binv_i(binv_i),
    .sum_o(sum_raw), .prop_o(prop_raw), .carry_o(carry_raw)
  );

  addsub_unk_track #(.W(W)) u_unk (
    .a_unk_i(a_unk_fit), .b_unk_i(b_unk_fit),
    .cin_unk_i(cin_unk_i), .binv_unk_i(binv_unk_i),
    .sum_unk_o(sum_unk_o), .prop_unk_o(prop_unk_o), .carry_unk_o(carry_unk_o)
  );

  assign sum_o   = sum_raw   & ~sum_unk_o;
  assign prop_o  = prop_raw  & ~prop_unk_o;
  assign carry_o = carry_raw & ~carry_unk_o;

  logic [W:0] wide_sum;
  assign wide_sum = {1'b0, a_fit} + {1'b0, b_fit ^ {W{binv_i}}} + {{W{1'b0}}, cin_i};

  always_comb begin
    AST_SUM_ARITH: assert (sum_raw == wide_sum[W-1:0])
      else $error("ripple sum differs from arithmetic sum"); // R2
    AST_TOP_CARRY: assert (carry_raw[W-1] == wide_sum[W])
      else $error("top carry differs from arithmetic carry"); // R3
    AST_MASKED_ZERO: assert (((sum_o & sum_unk_o) | (prop_o & prop_unk_o) | (carry_o & carry_unk_o)) == '0)
      else $error("flagged data bit not zero"); // R8
    AST_ANY_FLAG: assert (!(cin_unk_i || binv_unk_i) || ((&sum_unk_o) && (&carry_unk_o)))
      else $error("control flag did not flag sum and carries"); // R6
  end
endmodule

// File: tb/tb_addsub_carry_cell.sv
module tb_addsub_carry_cell;
  localparam int AW = 6;
  localparam int BW = 10;
  localparam int W  = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] opa, opa_unk;
  logic [BW-1:0] opb, opb_unk;
  logic cin, binv, cin_unk, binv_unk;
  logic [W-1:0] sum, prop, carry, sum_unk, prop_unk, carry_unk;

  int checks = 0;
  int errors = 0;

  addsub_carry_cell #(.A_W(AW), .B_W(BW), .W(W), .A_SIGNED(1'b1), .B_SIGNED(1'b0)) dut (
    .opa_i(opa), .opb_i(opb), .cin_i(cin), .binv_i(binv),
    .opa_unk_i(opa_unk), .opb_unk_i(opb_unk), .cin_unk_i(cin_unk), .binv_unk_i(binv_unk),
    .sum_o(sum), .prop_o(prop), .carry_o(carry),
    .sum_unk_o(sum_unk), .prop_unk_o(prop_unk), .carry_unk_o(carry_unk)
  );

  // entry = {a[5:0], b[9:0], cin, binv}
  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    {6'h00, 10'h000, 1'b0, 1'b0},
    {6'h01, 10'h001, 1'b0, 1'b0},
    {6'h1F, 10'h0FF, 1'b1, 1'b0},
    {6'h20, 10'h080, 1'b0, 1'b0},
    {6'h3F, 10'h001, 1'b0, 1'b0},
    {6'h15, 10'h2AA, 1'b1, 1'b0},
    {6'h0A, 10'h003, 1'b1, 1'b1},
    {6'h03, 10'h00A, 1'b1, 1'b1},
    {6'h2C, 10'h3C5, 1'b0, 1'b1},
    {6'h3F, 10'h3FF, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic apply(input logic [AW-1:0] a, input logic [BW-1:0] b, input logic ci, input logic bi,
                       input logic [AW-1:0] au, input logic [BW-1:0] bu, input logic cu, input logic biu);
    @(posedge clk);
    opa = a; opb = b; cin = ci; binv = bi;
    opa_unk = au; opb_unk = bu; cin_unk = cu; binv_unk = biu;
    @(negedge clk);
  endtask

  // reference from the requirements, built with arithmetic operators
  task automatic check_all();
    logic [W-1:0] ea, eb, beff, x, y, co, eau, ebu, pu, au_all;
    logic [W:0] s;
    logic any;
    ea = {{(W-AW){opa[AW-1]}}, opa};
    eb = opb[W-1:0];
    eau = {{(W-AW){opa_unk[AW-1]}}, opa_unk};
    ebu = opb_unk[W-1:0];
    beff = eb ^ {W{binv}};
    x = ea ^ beff;
    s = {1'b0, ea} + {1'b0, beff} + {{W{1'b0}}, cin};
    y = s[W-1:0];
    for (int i = 0; i < W; i++) begin
      logic [W:0] m, p;
      m = (({{W{1'b0}}, 1'b1}) << (i + 1)) - 1;
      p = ({1'b0, ea} & m) + ({1'b0, beff} & m) + {{W{1'b0}}, cin};
      co[i] = p[i+1];
    end
    any = (|eau) | (|ebu) | cin_unk | binv_unk;
    au_all = {W{any}};
    pu = eau | ebu | {W{binv_unk}};
    chk("R2 sum", sum, y & ~au_all);
    chk("R1 prop", prop, x & ~pu);
    chk("R3 carry", carry, co & ~au_all);
    chk("R6 sum_unk", sum_unk, au_all);
    chk("R6 carry_unk", carry_unk, au_all);
    chk("R7 prop_unk", prop_unk, pu);
  endtask

  initial begin
    opa = '0; opb = '0; cin = 0; binv = 0; opa_unk = '0; opb_unk = '0; cin_unk = 0; binv_unk = 0;
    @(negedge clk);
    chk("R2 idle sum", sum, 8'h00);
    chk("R3 idle carry", carry, 8'h00);

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][17:12], VEC[v][11:2], VEC[v][1], VEC[v][0], '0, '0, 1'b0, 1'b0);
      check_all();
    end

    // R4 subtraction with borrow and without
    apply(6'd5, 10'd9, 1'b1, 1'b1, '0, '0, 1'b0, 1'b0);
    chk("R4 diff", sum, 8'hFC);
    chk("R4 borrow", {7'b0, carry[W-1]}, 8'h00);
    apply(6'd9, 10'd5, 1'b1, 1'b1, '0, '0, 1'b0, 1'b0);
    chk("R4 diff", sum, 8'h04);
    chk("R4 no borrow", {7'b0, carry[W-1]}, 8'h01);
    // R4/R5 sign-extended -1 minus truncated 0x3FF -> 0, no borrow
    apply(6'h3F, 10'h3FF, 1'b1, 1'b1, '0, '0, 1'b0, 1'b0);
    chk("R5 diff", sum, 8'h00);
    chk("R4 top carry", {7'b0, carry[W-1]}, 8'h01);
    // R5 sign extension visible on propagate
    apply(6'h3F, 10'h000, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0);
    chk("R5 sign ext", prop, 8'hFF);
    apply(6'h1F, 10'h300, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0);
    chk("R5 truncate", sum, 8'h1F);
    // R9 cin flag alone
    apply(6'h0C, 10'h005, 1'b1, 1'b0, '0, '0, 1'b1, 1'b0);
    chk("R9 prop", prop, 8'h09);
    chk("R9 prop_unk", prop_unk, 8'h00);
    chk("R8 sum zeroed", sum, 8'h00);
    check_all();
    // R7/R8 flagged A bit during subtraction
    apply(6'h0A, 10'h003, 1'b1, 1'b1, 6'h04, '0, 1'b0, 1'b0);
    chk("R7 prop_unk", prop_unk, 8'h04);
    chk("R8 carry zeroed", carry, 8'h00);
    check_all();
    // R7 binv flag
    apply(6'h0A, 10'h003, 1'b1, 1'b1, '0, '0, 1'b0, 1'b1);
    chk("R7 all prop_unk", prop_unk, 8'hFF);
    chk("R8 prop zeroed", prop, 8'h00);
    // R5 sign-extended flag
    apply(6'h01, 10'h000, 1'b0, 1'b0, 6'h20, '0, 1'b0, 1'b0);
    chk("R5 flag ext", prop_unk, 8'hE0);
    check_all();
    // R5/R6 flags of dropped B bits have no effect
    apply(6'h01, 10'h002, 1'b0, 1'b0, '0, 10'h300, 1'b0, 1'b0);
    chk("R6 dropped flag", sum_unk, 8'h00);
    chk("R5 dropped flag sum", sum, 8'h03);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule